// File: doc/BRIEF.md
# Test Completion Mailbox Monitor

This block watches one 32-bit mailbox word in memory that test software writes when it has finished. Each time the processor retires an instruction, the monitor issues one read of the mailbox at a fixed byte address. A zero word means the test is still running. The first nonzero word ends the test: the monitor raises a sticky done flag, takes the word shifted right by one bit as the exit code, and reports pass when that code is zero and fail when it is not.

The read port allows one request in flight. Retirements that arrive while a read is outstanding are counted. Each of them later gets its own read, so every instruction still leads to one inspection of the word. Once done is set, a halt output tells the processor to stop retiring, and the monitor ignores any further retirement.

Top module: `mbx_monitor`

## Requirements
- R1: While reset is active, and immediately after it, done, pass, fail, halt and rdReq are 0 and exitCode is 0.
- R2: Before done, every accepted retirement (retireValid high for one cycle) causes exactly one rdReq pulse. rdReq is high for a single cycle, at most one read is outstanding, and retirements that arrive during an outstanding read are queued and read later in turn.
- R3: A read that returns the value 0 leaves done, pass, fail and exitCode unchanged.
- R4: A read that returns any nonzero value sets done in the cycle after rdValid.
- R5: When done is set, exitCode equals bits 31:1 of the returned word (the word logically shifted right by one), and exitCode holds that value until reset.
- R6: With done set, exactly one of pass and fail is high. pass is high when the exit code is 0, and fail is high otherwise. With done clear, both are 0.
- R7: After done is set, done, pass, fail and exitCode stay constant until reset, and no further rdReq is issued, even when retireValid is pulsed.
- R8: halt is high exactly when done is high.
- R9: rdAddr always carries the configured mailbox byte address, parameter MBX_ADDR (default 0x0000_1000), and every read is a full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | One-cycle pulse per retired instruction |
| halt | output | 1 | Asks the processor to stop retiring |
| rdReq | output | 1 | One-cycle mailbox read request |
| rdAddr | output | ADDR_W (32) | Mailbox byte address |
| rdValid | input | 1 | Read data valid; no earlier than one cycle after rdReq |
| rdData | input | DATA_W (32) | Mailbox word returned by the read |
| done | output | 1 | Test finished (sticky) |
| pass | output | 1 | Test passed (sticky) |
| fail | output | 1 | Test failed (sticky) |
| exitCode | output | DATA_W-1 (31) | Returned word shifted right by one |

## Verification
The assertions check on every cycle that pass and fail are mutually exclusive with done as their guard, that the verdict and exit code freeze once done is set, that a nonzero capture sets done on the next edge with the shifted code, that a zero capture never does, and that rdReq is a single-cycle pulse that stops after done. Only the bench's scenarios can show that the number of reads matches the number of retirements when retirements pile up during slow reads, and that pass and fail follow the expected code for specific words such as 1, 2, 0xB and all ones. The same holds for words drawn at random after a random run of zero reads.

// File: rtl/mbx_monitor_pkg.sv
package mbx_monitor_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } mbx_state_t;

  typedef struct packed {
    logic capture;
  } mbx_strobe_t;

endpackage

// File: rtl/mbx_monitor_ctl.sv
module mbx_monitor_ctl
  import mbx_monitor_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        retireValid,
  input  logic        rdValid,
  input  logic        wordNonZero,
  input  logic        doneIn,
  output logic        rdReq,
  output mbx_strobe_t strobe
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  mbx_state_t        state, stateNext;
  logic [PEND_W-1:0] pending, pendNext, pendSum;
  logic              reqNext, retireTake;

  always_comb begin
    strobe.capture = (state == ST_WAIT) && rdValid;
  end

  always_comb begin
    retireTake = retireValid && !doneIn;
    pendSum    = (retireTake && (pending != PEND_MAX)) ? pending + PEND_W'(1) : pending;
    stateNext  = state;
    pendNext   = pending;
    reqNext    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (retireTake) begin
          reqNext   = 1'b1;
          stateNext = ST_WAIT;
        end
      end
      default: begin
        if (rdValid) begin
          if (wordNonZero) begin
            stateNext = ST_IDLE;
            pendNext  = '0;
          end else if (pendSum != '0) begin
            reqNext  = 1'b1;
            pendNext = pendSum - PEND_W'(1);
          end else begin
            stateNext = ST_IDLE;
            pendNext  = '0;
          end
        end else begin
          pendNext = pendSum;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= '0;
      rdReq   <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendNext;
      rdReq   <= reqNext;
    end
  end

  // R2: a request is a single-cycle pulse
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R7: no request once the test has finished
  a_r7_no_req_after_done: assert property (@(posedge clk) disable iff (!rstN)
    doneIn |=> !rdReq);

endmodule

// File: rtl/mbx_monitor_dp.sv
module mbx_monitor_dp
  import mbx_monitor_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbx_strobe_t       strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic              wordNonZero,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [DATA_W-2:0] exitCode
);

  logic [DATA_W-2:0] shifted;

  always_comb begin
    wordNonZero = |rdData;
    shifted     = rdData[DATA_W-1:1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done     <= 1'b0;
      pass     <= 1'b0;
      fail     <= 1'b0;
      exitCode <= '0;
    end else if (strobe.capture && wordNonZero && !done) begin
      done     <= 1'b1;
      exitCode <= shifted;
      pass     <= (shifted == '0);
      fail     <= (shifted != '0);
    end
  end

  // R4: a nonzero captured word finishes the test on the next edge
  a_r4_done_after_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && (rdData != '0)) |=> done);

  // R3: a zero word leaves an unfinished test running
  a_r3_zero_keeps_running: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && (rdData == '0) && !done) |=> !done);

  // R5: the code is the captured word without its lowest bit
  a_r5_code_shift: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (exitCode == $past(rdData[DATA_W-1:1])));

  // R6: one verdict with done, none without
  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    done ? $onehot({pass, fail}) : !(pass || fail));

  // R6: pass only with a zero code
  a_r6_pass_code: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> (exitCode == '0));

  // R7: the outcome is frozen after done
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && $stable(pass) && $stable(fail) && $stable(exitCode)));

endmodule

// File: rtl/mbx_monitor.sv
module mbx_monitor
  import mbx_monitor_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          PEND_W   = 4,
  parameter logic [31:0] MBX_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  output logic              halt,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [DATA_W-2:0] exitCode
);

  mbx_strobe_t strobe;
  logic        wordNonZero;

  assign rdAddr = ADDR_W'(MBX_ADDR);
  assign halt   = done;

  mbx_monitor_ctl #(.PEND_W(PEND_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .retireValid (retireValid),
    .rdValid     (rdValid),
    .wordNonZero (wordNonZero),
    .doneIn      (done),
    .rdReq       (rdReq),
    .strobe      (strobe)
  );

  mbx_monitor_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdData      (rdData),
    .wordNonZero (wordNonZero),
    .done        (done),
    .pass        (pass),
    .fail        (fail),
    .exitCode    (exitCode)
  );

endmodule

// File: tb/mbx_monitor_bench.sv
`timescale 1ns/1ps
module mbx_monitor_bench;

  localparam logic [31:0] ADDR = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retireValid = 1'b0;
  logic        halt, rdReq, rdValid, done, pass, fail;
  logic [31:0] rdAddr, rdData;
  logic [30:0] exitCode;

  logic [31:0] mbxWord = 32'h0;
  int          reqCount = 0;
  int          memCnt = 0;
  int          compared = 0;
  int          mismatched = 0;

  always #4 clk = ~clk;

  mbx_monitor u_mbx_monitor (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .halt(halt),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .done(done), .pass(pass), .fail(fail), .exitCode(exitCode)
  );

  // memory model: answers each request one to three cycles later
  initial begin
    rdValid = 1'b0;
    rdData  = 32'h0;
    forever begin
      @(negedge clk);
      rdValid = 1'b0;
      if (!rstN) begin
        memCnt = 0;
      end else begin
        if (memCnt > 0) begin
          memCnt = memCnt - 1;
          if (memCnt == 0) begin
            rdValid = 1'b1;
            rdData  = mbxWord;
          end
        end
        if (rdReq) begin
          reqCount = reqCount + 1;
          memCnt   = int'($urandom_range(3, 1));
        end
      end
    end
  end

  function automatic logic [30:0] expCode(input logic [31:0] w);
    return w[31:1];
  endfunction

  function automatic logic expPass(input logic [31:0] w);
    return (w != 0) && (w[31:1] == 31'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    retireValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic retireOne();
    @(negedge clk);
    retireValid = 1'b1;
    @(negedge clk);
    retireValid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOutcome(input string tag, input logic [31:0] w);
    check({tag, " R4 done"}, 32'(done), 32'(w != 0));
    check({tag, " R5 code"}, 32'(exitCode), (w != 0) ? 32'(expCode(w)) : 32'h0);
    check({tag, " R6 pass"}, 32'(pass), 32'(expPass(w)));
    check({tag, " R6 fail"}, 32'(fail), 32'((w != 0) && !expPass(w)));
    check({tag, " R8 halt"}, 32'(halt), 32'(w != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h5eed));
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 done", 32'(done), 0);
    check("R1 pass", 32'(pass), 0);
    check("R1 fail", 32'(fail), 0);
    check("R1 halt", 32'(halt), 0);
    check("R1 rdReq", 32'(rdReq), 0);
    check("R1 code", 32'(exitCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 rdAddr", rdAddr, ADDR);

    // R3 and R2: zero mailbox, spaced retirements
    mbxWord = 32'h0;
    base = reqCount;
    for (int i = 0; i < 6; i++) begin
      retireOne();
      settle(6);
    end
    check("R2 reads per retire", 32'(reqCount - base), 6);
    check("R3 zero keeps running", 32'(done), 0);
    check("R3 code unchanged", 32'(exitCode), 0);

    // R2: back-to-back retirements queue behind the outstanding read
    base = reqCount;
    @(negedge clk);
    retireValid = 1'b1;
    repeat (5) @(negedge clk);
    retireValid = 1'b0;
    settle(40);
    check("R2 queued reads", 32'(reqCount - base), 5);
    check("R3 still running", 32'(done), 0);

    // pass: word 1 gives code 0
    mbxWord = 32'h1;
    retireOne();
    settle(6);
    checkOutcome("pass", 32'h1);

    // R7: sticky, ignores retirement, no reads
    mbxWord = 32'h0;
    base = reqCount;
    retireOne();
    retireOne();
    settle(8);
    check("R7 no reads after done", 32'(reqCount - base), 0);
    check("R7 done sticky", 32'(done), 1);
    check("R7 pass sticky", 32'(pass), 1);
    check("R7 code held", 32'(exitCode), 0);

    // R1: reset clears a finished test
    resetDut();
    @(negedge clk);
    check("R1 cleared done", 32'(done), 0);
    check("R1 cleared halt", 32'(halt), 0);

    // directed failure words
    mbxWord = 32'h0000_000B;
    retireOne(); settle(6);
    checkOutcome("fail 0xB", 32'h0000_000B);
    resetDut();
    mbxWord = 32'h0000_0002;
    retireOne(); settle(6);
    checkOutcome("fail 0x2", 32'h0000_0002);
    resetDut();
    mbxWord = 32'hFFFF_FFFF;
    retireOne(); settle(6);
    checkOutcome("fail all ones", 32'hFFFF_FFFF);

    // random trials
    for (int t = 0; t < 24; t++) begin
      logic [31:0] w;
      int zeros;
      resetDut();
      zeros = int'($urandom_range(4, 0));
      mbxWord = 32'h0;
      for (int k = 0; k < zeros; k++) begin
        retireOne(); settle(5);
      end
      check("R3 random zero run", 32'(done), 0);
      w = $urandom();
      if (t % 4 == 0) w = 32'h1;
      if (w == 0) w = 32'h3;
      mbxWord = w;
      retireOne(); settle(6);
      checkOutcome("random", w);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule